// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter with Break

This block turns parallel words into asynchronous serial characters on a single output line that rests high. A word is written into a holding register together with an optional ninth bit. On the next character boundary, marked by a one-cycle baud tick, it is copied into a shift register and sent one bit per tick. The bits go out least significant first, between a low start bit and a high stop bit. Because the holding register and the shift register are separate, a second word can be written while the first is still on the line. Characters then follow one another with no gap.

Two flags report progress. The empty flag shows that the holding register can take a new word. The complete flag shows that the line has gone quiet: nothing is shifting and nothing is waiting. A ninth data bit and a parity bit can be switched on. The parity bit takes over the most significant data position, so the frame length does not change. When the transmitter is enabled, it first sends one all-ones character. A break request replaces data with all-zero characters. A length control sets whether each break character is three bit times longer than a normal frame. The baud tick comes from outside the block.

Top module: `sertx_core`

## Requirements
- R1: During and after reset, before any tick, `txd` is 1, `tx_empty` is 1 and `tx_done` is 1.
- R2: With `mode_nine`=0 and `par_en`=0, a data character lasts 10 tick periods. It is sent in this order: a 0 start bit, then data bits 0 through 7, then a 1 stop bit. Each bit appears on `txd` at the tick that starts its period.
- R3: With `mode_nine`=1, `wr_bit8` is sent as an extra data bit after data bit 7, and the character lasts 11 tick periods. With `mode_nine`=0, `wr_bit8` has no effect on the line.
- R4: With `par_en`=1, the top data position carries a parity bit instead of data. That is bit 7 in 8-bit mode and the ninth bit in 9-bit mode. The parity bit is computed over the data bits below it. With `par_odd`=0 the total number of ones in those bits plus parity is even; with `par_odd`=1 it is odd.
- R5: A write clears `tx_empty`. `tx_empty` sets again at the tick where the word enters the shift register. A word written while the previous one is shifting starts at the very next tick after that stop bit.
- R6: `tx_done` is 0 in each of these cases: a character is on the line, a word is pending, or the enable character has not yet been sent. It returns to 1 at the first tick after a final stop bit that has nothing to follow it. While `tx_done` is 1, `txd` is 1.
- R7: When `tx_en` rises, including when it is already high as reset ends, one character of all ones is sent first. Its length is the current frame length. A pending word waits behind it.
- R8: If `brk_req` is 1 at a character boundary, a break character of all zeros is sent ahead of any pending word. Its length is 10 ticks in 8-bit mode and 11 in 9-bit mode with `brk_long`=0, and 13 and 14 ticks with `brk_long`=1. `brk_req` is sampled only at boundaries, so a started break always runs to its full length.
- R9: With `tx_en`=0, the current character still finishes. After that no character starts, `txd` stays 1 and a pending word stays pending.
- R10: `txd` changes only at clock edges where `baud_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| tx_en | input | 1 | Transmitter enable |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Word to send |
| wr_bit8 | input | 1 | Extra data bit used in 9-bit mode |
| mode_nine | input | 1 | 1 selects the 9-bit character |
| par_en | input | 1 | 1 replaces the top data bit with parity |
| par_odd | input | 1 | 0 even parity, 1 odd parity |
| brk_req | input | 1 | Send break characters while high |
| brk_long | input | 1 | 1 adds three bit times to each break character |
| txd | output | 1 | Serial line, high when idle |
| tx_empty | output | 1 | Holding register can accept a word |
| tx_done | output | 1 | Line idle with nothing pending |

## Verification
The bench sweeps all eight combinations of 9-bit mode, parity enable and parity sense. In each combination it sends words back to back, so any mistake in where parity sits, or any stray stop bit left by the ninth-bit path, shows up as a wrong bit at a known tick. The bench writes each following word right after the empty flag rises. A design that set the flag late, or that paused one tick between characters, would put idle high where a start bit is expected. The bench also runs breaks in all four length and mode settings, and once with a word waiting behind them. A wrong break length shows up as high or low one tick too early. A break that could not hold off data would send the waiting word too soon. Finally, the bench disables the transmitter in the middle of a character. The character must still finish, nothing may follow it, and the all-ones character must be sent again when the transmitter is re-enabled.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
   // Kind of character picked at a boundary
   typedef enum logic [1:0] {
      CK_NONE = 2'd0,
      CK_IDLE = 2'd1,
      CK_BRK  = 2'd2,
      CK_DATA = 2'd3
   } ck_e;
endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_bit8,
   input  logic              take,
   output logic [DATA_W-1:0] hold_data,
   output logic              hold_b8,
   output logic              empty
);
   // A write wins over a same-cycle transfer: the new word stays pending.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_data <= '0;
         hold_b8   <= 1'b0;
         empty     <= 1'b1;
      end else if (wr_stb) begin
         hold_data <= wr_data;
         hold_b8   <= wr_bit8;
         empty     <= 1'b0;
      end else if (take) begin
         empty     <= 1'b1;
      end
   end
endmodule

// File: rtl/sertx_frame.sv
module sertx_frame
   import sertx_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int BRK_ADD = 3,
   parameter int PAR_HW  = 1,
   parameter int SR_W    = DATA_W + 3 + BRK_ADD,
   parameter int CW      = $clog2(SR_W + 1)
) (
   input  ck_e               kind,
   input  logic [DATA_W-1:0] data,
   input  logic              bit8,
   input  logic              nine,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              brk_long,
   output logic [SR_W-1:0]   vec,
   output logic [CW-1:0]     len
);
   localparam int LEN_S = DATA_W + 2;
   localparam int LEN_L = DATA_W + 3;

   logic [DATA_W:0] pay;
   logic [CW-1:0]   base;

   generate
      if (PAR_HW != 0) begin : g_par
         always_comb begin
            pay = {bit8 & nine, data};
            if (par_en) begin
               if (nine) pay[DATA_W]   = par_odd ^ (^data);
               else      pay[DATA_W-1] = par_odd ^ (^data[DATA_W-2:0]);
            end
         end
      end else begin : g_nopar
         always_comb pay = {bit8 & nine, data};
      end
   endgenerate

   assign base = nine ? CW'(LEN_L) : CW'(LEN_S);

   always_comb begin
      vec = '1;
      len = base;
      unique case (kind)
         CK_DATA: begin
            vec[0]          = 1'b0;
            vec[DATA_W+1:1] = pay;
            if (!nine) vec[DATA_W+1] = 1'b1;   // stop bit in the ninth slot
         end
         CK_BRK: begin
            vec = '0;
            len = base + (brk_long ? CW'(BRK_ADD) : CW'(0));
         end
         default: begin
            vec = '1;
         end
      endcase
   end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift #(
   parameter int SR_W = 14,
   parameter int CW   = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            ld_ok,
   input  logic [SR_W-1:0] ld_vec,
   input  logic [CW-1:0]   ld_len,
   output logic            txd,
   output logic            bnd,
   output logic            active
);
   logic [SR_W-1:0] sr;
   logic [CW-1:0]   remain;   // bits still to show after the current one

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr     <= '1;
         remain <= '0;
         txd    <= 1'b1;
         active <= 1'b0;
      end else if (tick) begin
         if (remain != '0) begin
            txd    <= sr[0];
            sr     <= {1'b1, sr[SR_W-1:1]};
            remain <= remain - CW'(1);
         end else if (ld_ok) begin
            txd    <= ld_vec[0];
            sr     <= {1'b1, ld_vec[SR_W-1:1]};
            remain <= ld_len - CW'(1);
            active <= 1'b1;
         end else begin
            txd    <= 1'b1;
            active <= 1'b0;
         end
      end
   end

   assign bnd = (remain == '0);
endmodule

// File: rtl/sertx_core.sv
module sertx_core
   import sertx_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int BRK_ADD = 3,
   parameter int PAR_HW  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              tx_en,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_bit8,
   input  logic              mode_nine,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              brk_req,
   input  logic              brk_long,
   output logic              txd,
   output logic              tx_empty,
   output logic              tx_done
);
   localparam int SR_W = DATA_W + 3 + BRK_ADD;
   localparam int CW   = $clog2(SR_W + 1);

   generate
      if (DATA_W < 2)            begin : g_bad_w   $error("DATA_W must be at least 2");   end
      if (BRK_ADD < 1)           begin : g_bad_brk $error("BRK_ADD must be at least 1");  end
      if (PAR_HW != 0 && PAR_HW != 1) begin : g_bad_par $error("PAR_HW must be 0 or 1"); end
   endgenerate

   logic              en_q, pre_pend;
   logic              bnd, active, ld_ok, take;
   logic [DATA_W-1:0] hold_data;
   logic              hold_b8;
   logic [SR_W-1:0]   ld_vec;
   logic [CW-1:0]     ld_len;
   ck_e               kind;

   // Enable edge arms one all-ones character
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         pre_pend <= 1'b0;
      end else begin
         en_q <= tx_en;
         if (tx_en && !en_q)                         pre_pend <= 1'b1;
         else if (baud_tick && bnd && tx_en && pre_pend) pre_pend <= 1'b0;
      end
   end

   // Boundary priority: enable character, then break, then data
   always_comb begin
      if (pre_pend)       kind = CK_IDLE;
      else if (brk_req)   kind = CK_BRK;
      else if (!tx_empty) kind = CK_DATA;
      else                kind = CK_NONE;
   end

   assign ld_ok   = tx_en && (kind != CK_NONE);
   assign take    = baud_tick && bnd && tx_en && (kind == CK_DATA);
   assign tx_done = !active && tx_empty && !pre_pend;

   sertx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_stb    (wr_stb),
      .wr_data   (wr_data),
      .wr_bit8   (wr_bit8),
      .take      (take),
      .hold_data (hold_data),
      .hold_b8   (hold_b8),
      .empty     (tx_empty)
   );

   sertx_frame #(
      .DATA_W (DATA_W), .BRK_ADD (BRK_ADD), .PAR_HW (PAR_HW),
      .SR_W   (SR_W),   .CW      (CW)
   ) u_frame (
      .kind     (kind),
      .data     (hold_data),
      .bit8     (hold_b8),
      .nine     (mode_nine),
      .par_en   (par_en),
      .par_odd  (par_odd),
      .brk_long (brk_long),
      .vec      (ld_vec),
      .len      (ld_len)
   );

   sertx_shift #(.SR_W(SR_W), .CW(CW)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (baud_tick),
      .ld_ok  (ld_ok),
      .ld_vec (ld_vec),
      .ld_len (ld_len),
      .txd    (txd),
      .bnd    (bnd),
      .active (active)
   );
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk
   import sertx_pkg::*;
(
   input logic clk,
   input logic rst_n,
   input logic baud_tick,
   input logic tx_en,
   input logic wr_stb,
   input logic txd,
   input logic tx_empty,
   input logic tx_done,
   input logic bnd,
   input ck_e  kind
);
   logic at_b;
   assign at_b = baud_tick && bnd;

   p_line_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !baud_tick |=> $stable(txd));
   p_write_clears_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !tx_empty);
   p_load_sets_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (at_b && tx_en && kind == CK_DATA && !wr_stb) |=> tx_empty);
   p_data_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (at_b && tx_en && kind == CK_DATA) |=> !txd);
   p_break_starts_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (at_b && tx_en && kind == CK_BRK) |=> !txd);
   p_enable_char_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (at_b && tx_en && kind == CK_IDLE) |=> txd);
   p_disabled_stays_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (at_b && !tx_en) |=> txd);
   p_done_line_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |-> (txd && tx_empty));
endmodule

bind sertx_core sertx_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .baud_tick (baud_tick),
   .tx_en     (tx_en),
   .wr_stb    (wr_stb),
   .txd       (txd),
   .tx_empty  (tx_empty),
   .tx_done   (tx_done),
   .bnd       (bnd),
   .kind      (kind)
);

// File: tb/sim_sertx_core.sv
module sim_sertx_core;
   logic       clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0, tx_en = 1'b0;
   logic       wr_stb = 1'b0, wr_bit8 = 1'b0, mode_nine = 1'b0;
   logic       par_en = 1'b0, par_odd = 1'b0, brk_req = 1'b0, brk_long = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       txd, tx_empty, tx_done;
   int         nchk = 0, nerr = 0;
   logic [7:0] dd [4];
   logic       bb [4];
   logic [15:0] fv;
   int         fl;

   always #10 clk = ~clk;

   sertx_core u0 (
      .clk (clk), .rst_n (rst_n), .baud_tick (baud_tick), .tx_en (tx_en),
      .wr_stb (wr_stb), .wr_data (wr_data), .wr_bit8 (wr_bit8),
      .mode_nine (mode_nine), .par_en (par_en), .par_odd (par_odd),
      .brk_req (brk_req), .brk_long (brk_long),
      .txd (txd), .tx_empty (tx_empty), .tx_done (tx_done)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // One tick pulse, then check the line holds until the next pulse (R10)
   task automatic tick();
      logic a;
      @(negedge clk) baud_tick = 1'b1;
      @(negedge clk) baud_tick = 1'b0;
      a = txd;
      repeat (2) @(negedge clk);
      chk("R10 line steady between ticks", txd, a);
   endtask

   task automatic wr(input logic [7:0] d, input logic b);
      @(negedge clk) begin wr_stb = 1'b1; wr_data = d; wr_bit8 = b; end
      @(negedge clk) wr_stb = 1'b0;
   endtask

   function automatic logic [15:0] fvec(input logic [7:0] d, input logic b8,
                                        input logic nine, input logic pe, input logic po);
      logic [8:0] p;
      p = {b8 & nine, d};
      if (pe) begin
         if (nine) p[8] = po ^ (^d);
         else      p[7] = po ^ (^d[6:0]);
      end
      return nine ? {5'b0, 1'b1, p, 1'b0} : {6'b0, 1'b1, p[7:0], 1'b0};
   endfunction

   task automatic frame_tag(input logic nine, input logic pe, output string t);
      t = pe ? "R4 parity frame" : (nine ? "R3 nine-bit frame" : "R2 frame");
   endtask

   initial begin
      string t;
      repeat (3) @(negedge clk);
      chk("R1 reset txd", txd, 1'b1);
      chk("R1 reset empty", tx_empty, 1'b1);
      chk("R1 reset done", tx_done, 1'b1);
      rst_n = 1'b1;
      tick();
      chk("R1 idle after reset", txd, 1'b1);

      // Enable: one all-ones character before the first word (R7)
      @(negedge clk) tx_en = 1'b1;
      @(negedge clk) chk("R7 done low after enable", tx_done, 1'b0);
      wr(8'h5A, 1'b1);
      chk("R5 empty cleared by write", tx_empty, 1'b0);
      for (int i = 0; i < 10; i++) begin
         tick();
         chk("R7 enable character high", txd, 1'b1);
      end
      chk("R7 word waits behind enable char", tx_empty, 1'b0);
      fv = fvec(8'h5A, 1'b1, 1'b0, 1'b0, 1'b0);
      for (int i = 0; i < 10; i++) begin
         tick();
         chk("R2 frame after enable", txd, fv[i]);
      end
      tick();
      chk("R6 done after last stop", tx_done, 1'b1);

      // Sweep: nine-bit x parity enable x parity sense, back-to-back words
      for (int c = 0; c < 8; c++) begin
         @(negedge clk) begin
            mode_nine = c[0]; par_en = c[1]; par_odd = c[2];
         end
         for (int k = 0; k < 4; k++) begin
            dd[k] = 8'({8'hA5, 8'h3C, 8'hFF, 8'h00} >> (8 * (3 - k))) ^ 8'(c * 37);
            bb[k] = k[0] ^ c[1];
         end
         frame_tag(c[0], c[1], t);
         wr(dd[0], bb[0]);
         fl = c[0] ? 11 : 10;
         for (int k = 0; k < 4; k++) begin
            fv = fvec(dd[k], bb[k], c[0], c[1], c[2]);
            for (int i = 0; i < fl; i++) begin
               tick();
               chk(t, txd, fv[i]);
               if (i == 0) begin
                  chk("R5 empty set on transfer", tx_empty, 1'b1);
                  if (k < 3) wr(dd[k+1], bb[k+1]);
               end
               if (i == fl / 2) chk("R6 done low mid character", tx_done, 1'b0);
            end
         end
         tick();
         chk("R6 line idle after last word", txd, 1'b1);
         chk("R6 done after last word", tx_done, 1'b1);
      end

      // Break ahead of a pending word, held for two characters (R8)
      @(negedge clk) begin
         mode_nine = 1'b0; par_en = 1'b0; par_odd = 1'b0; brk_long = 1'b0; brk_req = 1'b1;
      end
      wr(8'h33, 1'b0);
      for (int i = 0; i < 10; i++) begin
         tick();
         chk("R8 break low", txd, 1'b0);
         if (i == 0) chk("R8 word held behind break", tx_empty, 1'b0);
      end
      tick();
      chk("R8 second break low", txd, 1'b0);
      @(negedge clk) brk_req = 1'b0;
      for (int i = 1; i < 10; i++) begin
         tick();
         chk("R8 break runs to full length", txd, 1'b0);
      end
      fv = fvec(8'h33, 1'b0, 1'b0, 1'b0, 1'b0);
      for (int i = 0; i < 10; i++) begin
         tick();
         chk("R8 word after break", txd, fv[i]);
         if (i == 0) chk("R5 empty set after break", tx_empty, 1'b1);
      end
      tick();
      chk("R6 done after break and word", tx_done, 1'b1);

      // Break lengths in all four settings (R8)
      for (int m = 0; m < 4; m++) begin
         @(negedge clk) begin
            mode_nine = m[0]; brk_long = m[1]; brk_req = 1'b1;
         end
         fl = (m[0] ? 11 : 10) + (m[1] ? 3 : 0);
         tick();
         chk("R8 break first bit", txd, 1'b0);
         @(negedge clk) brk_req = 1'b0;
         for (int i = 1; i < fl; i++) begin
            tick();
            chk("R8 break length", txd, 1'b0);
         end
         tick();
         chk("R8 line high after break", txd, 1'b1);
         chk("R8 done after break", tx_done, 1'b1);
      end

      // Disable mid character (R9), then re-enable (R7)
      @(negedge clk) begin mode_nine = 1'b0; brk_long = 1'b0; end
      wr(8'hC3, 1'b0);
      fv = fvec(8'hC3, 1'b0, 1'b0, 1'b0, 1'b0);
      tick();
      chk("R9 start before disable", txd, fv[0]);
      @(negedge clk) tx_en = 1'b0;
      for (int i = 1; i < 10; i++) begin
         tick();
         chk("R9 current character finishes", txd, fv[i]);
      end
      wr(8'h96, 1'b0);
      for (int i = 0; i < 5; i++) begin
         tick();
         chk("R9 no character while disabled", txd, 1'b1);
      end
      chk("R9 word stays pending", tx_empty, 1'b0);
      @(negedge clk) tx_en = 1'b1;
      for (int i = 0; i < 10; i++) begin
         tick();
         chk("R7 enable character on re-enable", txd, 1'b1);
      end
      fv = fvec(8'h96, 1'b0, 1'b0, 1'b0, 1'b0);
      for (int i = 0; i < 10; i++) begin
         tick();
         chk("R9 pending word sent after re-enable", txd, fv[i]);
      end
      tick();
      chk("R6 done at end", tx_done, 1'b1);

      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      nchk++;
      nerr++;
      $display("FAIL watchdog R6 actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end
endmodule